// File: doc/BRIEF.md
# Speech Output Port with Memory-Mapped I/O Decode

This block sits between a processor's data bus and both main memory and a small speech output device. The bus carries a write enable, a 32-bit byte address, write data and read data. The block looks at each address and decides where it goes. The top 64 KiB of the address space belongs to I/O. Every address below that belongs to main memory, which sits outside the block. The block makes the memory write enable, the write enables for its own device registers, and the select for the read-data multiplexer.

Three device locations drive the speech device. The first is a 6-bit sound-unit code register. The second is an active-low load strobe register. The third is a read-only standby status. The device takes in the code when the strobe falls from 1 to 0. Software drives it with a fixed sequence: raise the strobe, poll until standby reads 1, write the code, then lower the strobe.

The standby input passes through a synchronizer before software can read it. The code and the strobe leave the block straight from registers.

Top module: `spk_mmio_port`

## Requirements
- R1: `mem_we` equals `bus_we` for any address below 0xFFFF0000 and is 0 for every address from 0xFFFF0000 to 0xFFFFFFFF.
- R2: A bus write to 0xFFFFFF00 stores write-data bits 5:0 in the code register, and `spk_code` shows the value after the next rising edge. Higher data bits are dropped.
- R3: A bus write to 0xFFFFFF04 stores write-data bit 0 in the strobe register, which drives `spk_load_n` from the next rising edge.
- R4: While `rst` is high at a rising edge, the code register clears to 0 and `spk_load_n` sets to 1.
- R5: A read at a memory address returns `mem_rdata` in the same cycle (select code 00).
- R6: A read at 0xFFFFFF00 returns the code register zero-extended to 32 bits (select code 01). A write in the same cycle does not show until the next cycle.
- R7: A read at 0xFFFFFF08 returns the standby input in bit 0 and zeros elsewhere (select code 10). The standby input passes through two flops, so a change becomes readable after the second rising edge.
- R8: With `bus_we` low, nothing changes: no register and no memory. A write to an I/O address other than the code and strobe locations leaves both registers unchanged and keeps `mem_we` at 0.
- R9: A read at any I/O address other than 0xFFFFFF00 and 0xFFFFFF08 returns 0, and that includes the strobe location.
- R10: `spk_load_n` falls only after a bus write of 0 to the strobe location. When the polling sequence runs, the device receives each code exactly once, in the order written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 32 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data |
| mem_we | output | 1 | Write enable to main memory |
| mem_rdata | input | 32 | Read data from main memory |
| spk_code | output | 6 | Sound-unit code to the device |
| spk_load_n | output | 1 | Active-low load strobe to the device |
| spk_standby | input | 1 | Device standby status, asynchronous |

## Verification
Two functions can fall in the same cycle: a write to the code register and the combinational read of that same register. The bench provokes this by writing a new code while it checks `bus_rdata` in that cycle. The read must return the old code, and the new one must appear only in the following cycle. A second overlap is a change on the standby input in the cycle where software reads the standby location. A behavioural two-entry history in the bench fixes which value each read must return. Both the history and the register copies are compared with the ports on every clock.

// File: rtl/spk_mmio_pkg.sv
package spk_mmio_pkg;
  typedef enum logic [1:0] {
    RSEL_MEM  = 2'b00,
    RSEL_CODE = 2'b01,
    RSEL_STBY = 2'b10,
    RSEL_ZERO = 2'b11
  } rsel_e;
endpackage

// File: rtl/spk_addr_decode.sv
module spk_addr_decode
  import spk_mmio_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] IO_BASE   = 32'hFFFF0000,
  parameter logic [31:0] CODE_ADDR = 32'hFFFFFF00,
  parameter logic [31:0] STRB_ADDR = 32'hFFFFFF04,
  parameter logic [31:0] STBY_ADDR = 32'hFFFFFF08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              mem_we,
  output logic              code_we,
  output logic              strb_we,
  output rsel_e             rsel
);
  logic is_io;

  always_comb begin
    is_io   = (bus_addr >= IO_BASE[ADDR_W-1:0]);
    mem_we  = bus_we && !is_io;
    code_we = bus_we && (bus_addr == CODE_ADDR[ADDR_W-1:0]);
    strb_we = bus_we && (bus_addr == STRB_ADDR[ADDR_W-1:0]);
    if (!is_io)                                   rsel = RSEL_MEM;
    else if (bus_addr == CODE_ADDR[ADDR_W-1:0])   rsel = RSEL_CODE;
    else if (bus_addr == STBY_ADDR[ADDR_W-1:0])   rsel = RSEL_STBY;
    else                                          rsel = RSEL_ZERO;
  end

  // R1: memory never written inside the I/O window
  assert_io_no_mem_we_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr >= IO_BASE[ADDR_W-1:0]) |-> !mem_we);

  // R8: at most one write target per cycle, none without bus_we
  assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, code_we, strb_we}) && (bus_we || !(mem_we || code_we || strb_we)));
endmodule

// File: rtl/spk_dev_regs.sv
module spk_dev_regs #(
  parameter int DATA_W      = 32,
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_we,
  input  logic              strb_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stby_in,
  output logic [CODE_W-1:0] code_q,
  output logic              load_n_q,
  output logic              stby_sync
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      load_n_q <= 1'b1;
    end else begin
      if (code_we) code_q   <= wdata[CODE_W-1:0];
      if (strb_we) load_n_q <= wdata[0];
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= stby_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], stby_in};
      end
    end
  endgenerate

  assign stby_sync = sync_q[SYNC_STAGES-1];

  // R8: code register holds without its write enable
  assert_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !code_we |=> $stable(code_q));

  // R3: strobe takes written bit 0
  assert_strobe_load_R3: assert property (@(posedge clk) disable iff (rst)
    strb_we |=> (load_n_q == $past(wdata[0])));

  // R10: strobe falls only after a strobe write
  assert_strobe_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(load_n_q) |-> $past(strb_we));
endmodule

// File: rtl/spk_rdata_mux.sv
module spk_rdata_mux
  import spk_mmio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  rsel_e             rsel,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CODE_W-1:0] code_q,
  input  logic              stby_sync,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    unique case (rsel)
      RSEL_MEM:  rdata = mem_rdata;
      RSEL_CODE: rdata = {{(DATA_W-CODE_W){1'b0}}, code_q};
      RSEL_STBY: rdata = {{(DATA_W-1){1'b0}}, stby_sync};
      default:   rdata = '0;
    endcase
  end

  // R6: code readback is zero-extended
  assert_code_zext_R6: assert property (@(posedge clk) disable iff (rst)
    (rsel == RSEL_CODE) |-> (rdata[DATA_W-1:CODE_W] == '0));

  // R9: unmapped I/O reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rsel == RSEL_ZERO) |-> (rdata == '0));
endmodule

// File: rtl/spk_mmio_port.sv
module spk_mmio_port
  import spk_mmio_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          CODE_W      = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] IO_BASE     = 32'hFFFF0000,
  parameter logic [31:0] CODE_ADDR   = 32'hFFFFFF00,
  parameter logic [31:0] STRB_ADDR   = 32'hFFFFFF04,
  parameter logic [31:0] STBY_ADDR   = 32'hFFFFFF08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CODE_W-1:0] spk_code,
  output logic              spk_load_n,
  input  logic              spk_standby
);
  logic  code_we, strb_we, stby_sync;
  rsel_e rsel;

  spk_addr_decode #(
    .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .CODE_ADDR(CODE_ADDR),
    .STRB_ADDR(STRB_ADDR), .STBY_ADDR(STBY_ADDR)
  ) u_dec (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .mem_we(mem_we), .code_we(code_we), .strb_we(strb_we), .rsel(rsel)
  );

  spk_dev_regs #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk(clk), .rst(rst), .code_we(code_we), .strb_we(strb_we),
    .wdata(bus_wdata), .stby_in(spk_standby), .code_q(spk_code),
    .load_n_q(spk_load_n), .stby_sync(stby_sync)
  );

  spk_rdata_mux #(
    .DATA_W(DATA_W), .CODE_W(CODE_W)
  ) u_mux (
    .clk(clk), .rst(rst), .rsel(rsel), .mem_rdata(mem_rdata),
    .code_q(spk_code), .stby_sync(stby_sync), .rdata(bus_rdata)
  );
endmodule

// File: tb/spk_mmio_port_bench.sv
module spk_mmio_port_bench;
  localparam logic [31:0] IO_BASE = 32'hFFFF0000;
  localparam logic [31:0] A_CODE  = 32'hFFFFFF00;
  localparam logic [31:0] A_STRB  = 32'hFFFFFF04;
  localparam logic [31:0] A_STBY  = 32'hFFFFFF08;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mem_we;
  logic [31:0] mem_rdata;
  logic [5:0]  spk_code;
  logic        spk_load_n;
  logic        spk_standby = 1'b1;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [64];
  logic [5:0]  code_m = '0;
  logic        load_m = 1'b1;
  logic        h1 = 1'b0, h2 = 1'b0;
  int          busy = 0;
  logic [5:0]  heard [$];

  always #5 clk = ~clk;

  spk_mmio_port u_spk_mmio_port (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .spk_code(spk_code), .spk_load_n(spk_load_n),
    .spk_standby(spk_standby)
  );

  assign mem_rdata = mem[bus_addr[7:2]];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, updated at every rising edge
  always @(posedge clk) begin
    if (rst) begin
      code_m = '0; load_m = 1'b1; h1 = 1'b0; h2 = 1'b0;
    end else begin
      h2 = h1; h1 = spk_standby;
      if (bus_we && bus_addr < IO_BASE) mem[bus_addr[7:2]] = bus_wdata;
      if (bus_we && bus_addr == A_CODE) code_m = bus_wdata[5:0];
      if (bus_we && bus_addr == A_STRB) load_m = bus_wdata[0];
    end
  end

  // device model: busy for a while after each latch
  always @(negedge spk_load_n) if (!rst) begin
    heard.push_back(spk_code);
    busy = 6;
  end
  always @(posedge clk) begin
    if (rst) spk_standby <= 1'b1;
    else if (busy > 0) begin busy = busy - 1; spk_standby <= 1'b0; end
    else spk_standby <= 1'b1;
  end

  // per-clock comparison of registered outputs (R2, R3, R4)
  always @(negedge clk) if (!rst) begin
    chk(spk_code == code_m, "R2 spk_code", {26'b0, spk_code}, {26'b0, code_m});
    chk(spk_load_n == load_m, "R3 spk_load_n", {31'b0, spk_load_n}, {31'b0, load_m});
  end

  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    if (a < IO_BASE)   return mem[a[7:2]];
    if (a == A_CODE)   return {26'b0, code_m};
    if (a == A_STBY)   return {31'b0, h2};
    return 32'h0;
  endfunction

  // one bus cycle: drive after falling edge, check combinational outputs
  task automatic bus(input bit we, input logic [31:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    #2;
    chk(bus_rdata == exp_rd(a), {tag, " rdata"}, bus_rdata, exp_rd(a));
    chk(mem_we == (we && a < IO_BASE), "R1 mem_we", {31'b0, mem_we}, {31'b0, (we && a < IO_BASE)});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] seq [5] = '{6'h1B, 6'h07, 6'h2D, 6'h0F, 6'h20};
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R4: reset state
    chk(spk_code == 6'h0, "R4 code reset", {26'b0, spk_code}, 32'h0);
    chk(spk_load_n == 1'b1, "R4 strobe reset", {31'b0, spk_load_n}, 32'h1);
    rst = 1'b0;

    // R1/R5: memory writes at boundary and readback
    bus(1'b1, 32'h0000_0010, 32'hCAFE_0001, "R5");
    bus(1'b1, 32'hFFFE_FFFC, 32'h1234_5678, "R1");
    bus(1'b1, 32'hFFFF_0000, 32'hDEAD_BEEF, "R1");
    bus(1'b0, 32'h0000_0010, 32'h0, "R5");
    bus(1'b0, 32'hFFFE_FFFC, 32'h0, "R5");
    bus(1'b0, 32'h0000_0000, 32'h0, "R1 io write kept out of memory");

    // R2/R6: only low bits kept; same-cycle read returns old value
    bus(1'b1, A_CODE, 32'hFFFF_FFFF, "R6 same-cycle old");
    bus(1'b0, A_CODE, 32'h0, "R6 zero-extended");
    bus(1'b1, A_CODE, 32'h0000_0155, "R2");
    bus(1'b0, A_CODE, 32'h0, "R6");

    // R8: no write enable, or unmapped I/O write
    bus(1'b0, A_CODE, 32'h0000_003A, "R8 no we");
    bus(1'b1, 32'hFFFF_FF0C, 32'hFFFF_FFFF, "R9 unmapped");
    bus(1'b0, A_CODE, 32'h0, "R8 code unchanged");
    // R9: strobe location and other I/O read as zero
    bus(1'b0, A_STRB, 32'h0, "R9 strobe read");
    bus(1'b0, 32'hFFFF_1234, 32'h0, "R9 io read");

    // R7/R10: polling sequence
    foreach (seq[k]) begin
      int guard;
      bus(1'b1, A_STRB, 32'h1, "R3");
      guard = 0;
      do begin
        bus(1'b0, A_STBY, 32'h0, "R7");
        guard++;
      end while (bus_rdata[0] !== 1'b1 && guard < 50);
      bus(1'b1, A_CODE, {26'b0, seq[k]}, "R2");
      bus(1'b1, A_STRB, 32'h0, "R10");
    end
    repeat (10) bus(1'b0, A_STBY, 32'h0, "R7 settle");

    chk(heard.size() == 5, "R10 latch count", heard.size(), 5);
    for (int k = 0; k < 5 && k < heard.size(); k++)
      chk(heard[k] == seq[k], "R10 latched code", {26'b0, heard[k]}, {26'b0, seq[k]});

    // R4: reset again mid-run
    @(negedge clk); rst = 1'b1; bus_we = 1'b0;
    @(negedge clk);
    chk(spk_code == 6'h0 && spk_load_n == 1'b1, "R4 re-reset",
        {25'b0, spk_load_n, spk_code}, 32'h40);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule